// File: doc/BRIEF.md
# LIN Error Status Flag Register

This block collects error and event indications from a LIN protocol engine and holds each one as a sticky flag in a single 32-bit status word. The frame engine pulses one strobe per detected problem: noise, overrun, framing, identifier parity, break delimiter, synch field, checksum or bit error. The block qualifies each strobe with the current role and control bits, then latches it. Software reads the status word at any time. It clears flags one at a time by writing a 1 to each flag's bit position. A write of 0 leaves a flag untouched.

Two flags come from logic inside the block. A dominant-bus watchdog counts bit-time ticks while the sampled receive line stays low. It reports a stuck bus the first time after 100 bit times, and again each time a further 87 bit times pass. A compare unit watches an 8-bit timer against two compare values and raises a match flag. It can also ask the protocol engine to drop to Idle, and it can have the match flag wiped while the controller is in initialization. An interrupt line is the OR of every flag.

Top module: `lin_err_status`

## Requirements
- R1: `status` uses LSB-0 numbering. Bits 31:16 and 6:1 always read 0. Flags sit at: stuck bus 15, compare match 14, bit error 13, checksum 12, synch field 11, break delimiter 10, identifier parity 9, framing 8, overrun 7, noise 0.
- R2: A one-cycle pulse on any of `noise_evt`, `overrun_evt`, `frame_evt`, `idpar_evt`, `delim_short_evt` or `sync_bad_evt` sets that flag. The flag is visible in `status` from the cycle after the pulse.
- R3: All flags reset to 0. When `wr_en` is 1, a flag clears on the next edge if its bit in `wr_data` is 1. Bits of `wr_data` that are 0 change nothing.
- R4: A hardware set and a software write-1 clear can hit the same flag in the same cycle. The flag then ends up set.
- R5: `bit_err_evt` sets the bit-error flag only when `in_header` is 0 or `is_master` is 1.
- R6: `sum_err_evt` sets the checksum flag only when both `sum_calc_off` and `sum_chk_off` are 0.
- R7: With `rx_level` held at 0 (dominant), the stuck-bus flag sets after the 100th `bit_tick` pulse since the line last went recessive.
- R8: If the line stays dominant after the first report, the stuck-bus flag sets again at tick 187, 274 and so on, every 87 ticks.
- R9: Any cycle with `rx_level` = 1 restarts the dominant count from zero. Cycles without `bit_tick` do not advance the count.
- R10: The compare flag sets on the first cycle that `timer_val` equals `cmp_a` or `cmp_b` after a cycle in which it matched neither.
- R11: `idle_req` is a single-cycle pulse, visible together with the newly set compare flag. It occurs only when `idle_on_cmp` was 1 in the match cycle.
- R12: While `init_mode` and `clr_cmp_in_init` are both 1, the compare flag is cleared and cannot set. When `clr_cmp_in_init` is 0, init mode leaves the flag alone.
- R13: `irq` is 1 exactly when at least one flag in `status` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per LIN bit time |
| rx_level | input | 1 | Sampled receive line, 0 = dominant |
| noise_evt | input | 1 | Noise strobe |
| overrun_evt | input | 1 | Receive overrun strobe |
| frame_evt | input | 1 | Framing (stop bit) error strobe |
| idpar_evt | input | 1 | Identifier parity error strobe |
| delim_short_evt | input | 1 | Break delimiter shorter than one bit |
| sync_bad_evt | input | 1 | Inconsistent synch field strobe |
| sum_err_evt | input | 1 | Received checksum mismatch strobe |
| bit_err_evt | input | 1 | Transmitted/read-back bit mismatch strobe |
| in_header | input | 1 | 1 while the header is being transmitted |
| is_master | input | 1 | 1 when the node acts as master |
| sum_calc_off | input | 1 | Checksum calculation disabled |
| sum_chk_off | input | 1 | Checksum field handled by software |
| timer_val | input | 8 | Free-running timer value |
| cmp_a | input | 8 | First compare value |
| cmp_b | input | 8 | Second compare value |
| init_mode | input | 1 | Controller in initialization mode |
| clr_cmp_in_init | input | 1 | Clear compare flag while in init mode |
| idle_on_cmp | input | 1 | Request Idle on compare match |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 32 | Write-1-to-clear mask |
| status | output | 32 | Status word |
| irq | output | 1 | OR of all flags |
| idle_req | output | 1 | One-cycle request to enter Idle |

## Verification
On every cycle the assertions check the following: reserved bits stay zero, a flag never falls without a matching write-1, a set wins over a same-cycle clear, masked checksum errors never set, and the init-mode clear holds. They also check that a stuck-bus report follows a dominant tick, and that the idle request accompanies a set compare flag. The exact tick counts of 100 and then 87, and the restart on a recessive sample, are shown only by the bench's long dominant runs. The same goes for the match points found by the full 8-bit timer sweep and the role and mask combinations.

// File: rtl/lin_err_pkg.sv
package lin_err_pkg;
  localparam int REG_W     = 32;
  localparam int NUM_FLAGS = 10;
  localparam int TMR_W     = 8;

  // Flag index; position in the status word is given by flag_pos().
  typedef enum int unsigned {
    F_NOISE   = 0,
    F_OVERRUN = 1,
    F_FRAME   = 2,
    F_IDPAR   = 3,
    F_DELIM   = 4,
    F_SYNC    = 5,
    F_SUM     = 6,
    F_BITERR  = 7,
    F_CMP     = 8,
    F_STUCK   = 9
  } flag_e;

  // Noise sits at bit 0, the rest pack upward from bit 7.
  function automatic int unsigned flag_pos(int unsigned idx);
    return (idx == 0) ? 0 : idx + 6;
  endfunction
endpackage

// File: rtl/lin_err_dom_watch.sv
module lin_err_dom_watch #(
  parameter int FIRST_SPAN  = 100,
  parameter int REPEAT_SPAN = 87
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_level,
  output logic stuck_hit
);
  localparam int CW = $clog2(FIRST_SPAN + 1);
  localparam logic [CW-1:0] LAST   = CW'(FIRST_SPAN - 1);
  localparam logic [CW-1:0] RELOAD = CW'(FIRST_SPAN - REPEAT_SPAN);

  logic [CW-1:0] dom_cnt;

  assign stuck_hit = !rx_level && bit_tick && (dom_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || rx_level) begin
      dom_cnt <= '0;
    end else if (bit_tick) begin
      if (dom_cnt == LAST) dom_cnt <= RELOAD;
      else                 dom_cnt <= dom_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lin_err_cmp.sv
module lin_err_cmp #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_val,
  input  logic [TW-1:0] cmp_a,
  input  logic [TW-1:0] cmp_b,
  input  logic          idle_on_cmp,
  input  logic          blocked,
  output logic          cmp_hit,
  output logic          idle_req
);
  logic match, match_q;

  assign match   = (timer_val == cmp_a) || (timer_val == cmp_b);
  assign cmp_hit = match && !match_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q  <= 1'b0;
      idle_req <= 1'b0;
    end else begin
      match_q  <= match;
      idle_req <= cmp_hit && idle_on_cmp && !blocked;
    end
  end
endmodule

// File: rtl/lin_err_flag_bank.sv
module lin_err_flag_bank #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] sw_clr_v,
  input  logic [N-1:0] hw_clr_v,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)           flags[i] <= 1'b0;
      else if (hw_clr_v[i]) flags[i] <= 1'b0;
      else if (set_v[i])    flags[i] <= 1'b1;
      else if (sw_clr_v[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/lin_err_status.sv
module lin_err_status
  import lin_err_pkg::*;
#(
  parameter int FIRST_SPAN  = 100,
  parameter int REPEAT_SPAN = 87
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             rx_level,
  input  logic             noise_evt,
  input  logic             overrun_evt,
  input  logic             frame_evt,
  input  logic             idpar_evt,
  input  logic             delim_short_evt,
  input  logic             sync_bad_evt,
  input  logic             sum_err_evt,
  input  logic             bit_err_evt,
  input  logic             in_header,
  input  logic             is_master,
  input  logic             sum_calc_off,
  input  logic             sum_chk_off,
  input  logic [TMR_W-1:0] timer_val,
  input  logic [TMR_W-1:0] cmp_a,
  input  logic [TMR_W-1:0] cmp_b,
  input  logic             init_mode,
  input  logic             clr_cmp_in_init,
  input  logic             idle_on_cmp,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] status,
  output logic             irq,
  output logic             idle_req
);
  logic [NUM_FLAGS-1:0] set_v, sw_clr_v, hw_clr_v, flags;
  logic stuck_hit, cmp_hit, cmp_block;

  assign cmp_block = init_mode && clr_cmp_in_init;

  lin_err_dom_watch #(
    .FIRST_SPAN (FIRST_SPAN),
    .REPEAT_SPAN(REPEAT_SPAN)
  ) u_dom (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .rx_level (rx_level),
    .stuck_hit(stuck_hit)
  );

  lin_err_cmp #(.TW(TMR_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .timer_val  (timer_val),
    .cmp_a      (cmp_a),
    .cmp_b      (cmp_b),
    .idle_on_cmp(idle_on_cmp),
    .blocked    (cmp_block),
    .cmp_hit    (cmp_hit),
    .idle_req   (idle_req)
  );

  always_comb begin
    set_v           = '0;
    set_v[F_NOISE]   = noise_evt;
    set_v[F_OVERRUN] = overrun_evt;
    set_v[F_FRAME]   = frame_evt;
    set_v[F_IDPAR]   = idpar_evt;
    set_v[F_DELIM]   = delim_short_evt;
    set_v[F_SYNC]    = sync_bad_evt;
    set_v[F_SUM]     = sum_err_evt && !sum_calc_off && !sum_chk_off;
    set_v[F_BITERR]  = bit_err_evt && (!in_header || is_master);
    set_v[F_CMP]     = cmp_hit;
    set_v[F_STUCK]   = stuck_hit;
    hw_clr_v         = '0;
    hw_clr_v[F_CMP]  = cmp_block;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_map
    localparam int unsigned POS = flag_pos(i);
    assign sw_clr_v[i] = wr_en && wr_data[POS];
  end

  lin_err_flag_bank #(.N(NUM_FLAGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_v   (set_v),
    .sw_clr_v(sw_clr_v),
    .hw_clr_v(hw_clr_v),
    .flags   (flags)
  );

  always_comb begin
    status = '0;
    for (int i = 0; i < NUM_FLAGS; i++) status[flag_pos(i)] = flags[i];
  end

  assign irq = |flags;
endmodule

// File: rtl/lin_err_status_chk.sv
module lin_err_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bit_tick,
  input logic        rx_level,
  input logic        noise_evt,
  input logic        sum_err_evt,
  input logic        sum_calc_off,
  input logic        sum_chk_off,
  input logic        init_mode,
  input logic        clr_cmp_in_init,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] status,
  input logic        idle_req
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[31:16] == 16'h0 && status[6:1] == 6'h0);

  // R3
  for (genvar p = 7; p < 14; p++) begin : g_fall
    no_silent_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[p]) |-> $past(wr_en && wr_data[p]));
  end

  // R3
  noise_no_silent_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> $past(wr_en && wr_data[0]));

  // R4
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_evt && wr_en && wr_data[0]) |=> status[0]);

  // R6
  sum_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[12] && (sum_calc_off || sum_chk_off)) |=> !status[12]);

  // R6
  sum_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[12]) |-> $past(sum_err_evt));

  // R7
  stuck_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[15]) |-> $past(bit_tick && !rx_level));

  // R11
  idle_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req |-> status[14]);

  // R11
  idle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req |=> !idle_req);

  // R12
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_mode && clr_cmp_in_init) |=> !status[14]);
endmodule

bind lin_err_status lin_err_status_chk chk_i (.*);

// File: tb/lin_err_status_test.sv
module lin_err_status_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 0, rx_level = 1;
  logic [7:0] evt = '0;
  logic in_header = 0, is_master = 0, sum_calc_off = 0, sum_chk_off = 0;
  logic [7:0] timer_val = 8'd0, cmp_a = 8'd37, cmp_b = 8'd200;
  logic init_mode = 0, clr_cmp_in_init = 0, idle_on_cmp = 0;
  logic wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] status;
  logic irq, idle_req;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lin_err_status uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_level(rx_level),
    .noise_evt(evt[0]), .overrun_evt(evt[1]), .frame_evt(evt[2]),
    .idpar_evt(evt[3]), .delim_short_evt(evt[4]), .sync_bad_evt(evt[5]),
    .sum_err_evt(evt[6]), .bit_err_evt(evt[7]),
    .in_header(in_header), .is_master(is_master),
    .sum_calc_off(sum_calc_off), .sum_chk_off(sum_chk_off),
    .timer_val(timer_val), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .init_mode(init_mode), .clr_cmp_in_init(clr_cmp_in_init),
    .idle_on_cmp(idle_on_cmp), .wr_en(wr_en), .wr_data(wr_data),
    .status(status), .irq(irq), .idle_req(idle_req)
  );

  // R1: event index i maps to bit 0 for noise, else i+6.
  function automatic int pos_of(int i);
    return (i == 0) ? 0 : i + 6;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1; wr_data = d; cyc(); wr_en = 0; wr_data = '0;
  endtask

  task automatic tick_low();
    rx_level = 0; bit_tick = 1; cyc(); bit_tick = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int fires, fire_at[4], hits;
    repeat (3) cyc();
    chk("R3 reset status", status, 32'h0);
    chk("R13 reset irq", {31'h0, irq}, 32'h0);
    rst_n = 1;
    cyc();

    // R2 R3 R13: sweep every strobe-driven flag
    for (int i = 0; i < 8; i++) begin
      logic [31:0] m;
      m = 32'h1 << pos_of(i);
      evt[i] = 1; cyc(); evt[i] = 0;
      chk($sformatf("R2 set flag %0d", i), status, m);
      chk("R13 irq high", {31'h0, irq}, 32'h1);
      wr(~m);
      chk("R3 other bits ignored", status, m);
      wr(32'h0);
      chk("R3 write zero ignored", status, m);
      wr(m);
      chk("R3 write one clears", status, 32'h0);
      chk("R13 irq low", {31'h0, irq}, 32'h0);
      // R4: set and clear together
      evt[i] = 1; wr_en = 1; wr_data = m; cyc(); evt[i] = 0; wr_en = 0;
      chk("R4 set beats clear", status, m);
      wr(m);
    end

    // R1: all flags up, reserved bits still zero
    evt = 8'hFF; cyc(); evt = '0;
    chk("R1 layout", status, 32'h0000_3F81);
    wr(32'hFFFF_FFFF);
    chk("R1 cleared", status, 32'h0);

    // R5: bit error role/phase combinations
    for (int c = 0; c < 4; c++) begin
      in_header = c[0]; is_master = c[1];
      evt[7] = 1; cyc(); evt[7] = 0;
      chk($sformatf("R5 hdr=%0d mst=%0d", c[0], c[1]), status,
          (!c[0] || c[1]) ? 32'h2000 : 32'h0);
      wr(32'h2000);
    end
    in_header = 0; is_master = 0;

    // R6: checksum masking combinations
    for (int c = 0; c < 4; c++) begin
      sum_calc_off = c[0]; sum_chk_off = c[1];
      evt[6] = 1; cyc(); evt[6] = 0;
      chk($sformatf("R6 off=%0d%0d", c[1], c[0]), status,
          (c == 0) ? 32'h1000 : 32'h0);
      wr(32'h1000);
    end
    sum_calc_off = 0; sum_chk_off = 0;

    // R7 R8: long dominant run
    rx_level = 1; cyc();
    fires = 0;
    for (int t = 1; t <= 280; t++) begin
      tick_low();
      if (status[15]) begin
        if (fires < 4) fire_at[fires] = t;
        fires++;
        wr(32'h8000);
      end
    end
    chk("R7 report count", fires, 3);
    chk("R7 first report tick", fire_at[0], 100);
    chk("R8 second report tick", fire_at[1], 187);
    chk("R8 third report tick", fire_at[2], 274);

    // R9: recessive restart and no counting without tick
    rx_level = 1; cyc();
    for (int t = 0; t < 99; t++) tick_low();
    rx_level = 1; cyc();
    for (int t = 0; t < 99; t++) tick_low();
    chk("R9 restart on recessive", status, 32'h0);
    rx_level = 0; repeat (300) cyc();
    chk("R9 no tick no count", status, 32'h0);
    tick_low();
    chk("R9 report at 100th tick", status, 32'h8000);
    wr(32'h8000);
    rx_level = 1; cyc();

    // R10 R11: full timer sweep, idle request off then on
    for (int pass = 0; pass < 2; pass++) begin
      idle_on_cmp = pass[0];
      timer_val = 8'd0; cyc();
      hits = 0;
      for (int v = 1; v < 256; v++) begin
        bit exp_hit;
        exp_hit = (v == 37) || (v == 200);
        timer_val = v[7:0]; cyc();
        chk($sformatf("R10 v=%0d", v), {31'h0, status[14]}, {31'h0, exp_hit});
        chk($sformatf("R11 v=%0d", v), {31'h0, idle_req},
            {31'h0, exp_hit && pass[0]});
        if (status[14]) begin
          hits++;
          wr(32'h4000);
          chk("R11 single pulse", {31'h0, idle_req}, 32'h0);
          chk("R10 no refire while equal", status, 32'h0);
        end
      end
      chk("R10 match count", hits, 2);
    end
    idle_on_cmp = 0;

    // R12: init-mode clear
    timer_val = 8'd36; cyc();
    timer_val = 8'd37; cyc();
    init_mode = 1; cyc();
    chk("R12 init without clear mode keeps", status, 32'h4000);
    clr_cmp_in_init = 1; cyc();
    chk("R12 init clear", status, 32'h0);
    timer_val = 8'd36; cyc();
    timer_val = 8'd37; cyc();
    chk("R12 blocked in init", status, 32'h0);
    init_mode = 0; clr_cmp_in_init = 0; cyc();
    chk("R12 leaving init", status, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule